// File: doc/BRIEF.md
# Vectoring Eight-Level Interrupt Controller

This block sits on the memory bus of a small 8-bit processor. It gathers eight active-low interrupt request lines and one cascade line from a controller further down the chain, and drives one active-low interrupt output to the processor. Each request line is caught on its falling edge and held in a pending latch. A mask register decides which pending latches may pull the interrupt output low. Masked requests are still latched and still show in the status register.

When the processor answers an interrupt, it performs instruction fetches from the controller's address. The controller answers with a three-byte long-branch instruction. The first byte is the opcode. The second byte is a page byte held in a register. The third byte is a low address, built from base bits in the control register plus the winning level times a selectable interval of 4 or 8 bytes. The level is chosen by a fixed priority, and it is frozen when the opcode byte goes out. A small state machine tracks the fetch sequence. Its states are `FS_IDLE` (waiting for an opcode fetch), `FS_HI` (the page byte is next) and `FS_LO` (the low byte is next). Its transitions are *take_vector* (FS_IDLE to FS_HI on a fetch), *send_page* (FS_HI to FS_LO on a fetch) and *send_low* (FS_LO to FS_IDLE on a fetch). Without a fetch strobe the state holds.

All bus strobes are single-cycle synchronous pulses qualified by `cs`. Read data is registered and appears in the cycle after the strobe.

Top module: `vec_irq_ctrl`

## Requirements
- R1: A high-to-low step on `irq_n[i]`, seen between two rising clock edges, sets pending bit i at the second edge. A line held low sets nothing more. A set in the same cycle as a clear of that bit wins.
- R2: Priority is fixed: level 7 ranks highest and level 0 lowest, among pending bits whose mask bit is 0.
- R3: `int_n` is low exactly while some pending bit has mask bit 0, or `cascade_n` is low. A masked line is still latched.
- R4: A read with `sel`=3 returns the 8 pending bits, masked ones included, and clears all of them. Bit i of the returned byte stands for level i.
- R5: Writes go to the page register when `sel`=0, the control register when `sel`=1 and the mask register when `sel`=2. A mask bit of 1 masks that level. Reads of any `sel` other than 3 or 4 return 0x00.
- R6: Three fetches in a row return 0xC0, then the page register, then the low vector byte. The first fetch clears only the pending bit of the winning level. If no unmasked bit is pending, the level used is 0 and nothing is cleared. A fetch strobe takes precedence over a read strobe in the same cycle.
- R7: The low vector byte is `{ctrl[7:6], 6'b0}` plus the level shifted left by 3 when `ctrl[0]`=1, or by 2 when `ctrl[0]`=0.
- R8: A read with `sel`=4 returns `{valid, 4'b0000, level[2:0]}` for the current winner and clears nothing.
- R9: The level is captured on the opcode fetch. A new request during the sequence does not change the low vector byte.
- R10: Reset clears all pending bits, the page, the control register, the read data and the state. It sets every mask bit, so `int_n` is high.
- R11: `cascade_n` is a level input and is never latched. It drives only `int_n`. It does not affect the status, polling or vector bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_n | input | 8 | Active-low request lines, caught on falling edge |
| cascade_n | input | 1 | Active-low interrupt from a downstream controller |
| cs | input | 1 | Chip select, qualifies all strobes |
| sel | input | 3 | Register select |
| rd | input | 1 | Register read strobe |
| wr | input | 1 | Register write strobe |
| fetch | input | 1 | Instruction fetch strobe for the vector sequence |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read or fetch data |
| int_n | output | 1 | Active-low interrupt to the processor |

## Verification
The assertions assume that the request lines and strobes are synchronous to `clk` and stable at the rising edge. They also assume that every strobe lasts exactly one cycle, so one strobe is one access. The bench drives every input at the falling edge only. It issues each strobe for a single cycle, and it keeps the random traffic to the defined `sel` codes plus a few unused ones. Random fetch pulses may start or break off a sequence at any point. This exercises the hold behaviour of the state machine, but it never violates the one-strobe-per-access premise.

// File: rtl/vic_pkg.sv
package vic_pkg;
    typedef enum logic [1:0] {
        FS_IDLE = 2'd0,
        FS_HI   = 2'd1,
        FS_LO   = 2'd2
    } fetch_st_t;

    localparam logic [7:0] LBR_OPCODE = 8'hC0;

    localparam logic [2:0] SEL_PAGE = 3'd0;
    localparam logic [2:0] SEL_CTRL = 3'd1;
    localparam logic [2:0] SEL_MASK = 3'd2;
    localparam logic [2:0] SEL_STAT = 3'd3;
    localparam logic [2:0] SEL_POLL = 3'd4;
endpackage

// File: rtl/vic_latch_bank.sv
module vic_latch_bank #(
    parameter int N_IRQ = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_IRQ-1:0] req_n,
    input  logic             clr_all,
    input  logic [N_IRQ-1:0] clr_one,
    output logic [N_IRQ-1:0] pend,
    output logic [N_IRQ-1:0] fall
);
    logic [N_IRQ-1:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '1;
        else        prev_q <= req_n;
    end

    assign fall = prev_q & ~req_n;

    for (genvar i = 0; i < N_IRQ; i++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                      pend[i] <= 1'b0;
            else if (fall[i])                pend[i] <= 1'b1;
            else if (clr_all || clr_one[i])  pend[i] <= 1'b0;
        end
    end
endmodule

// File: rtl/vic_prio.sv
module vic_prio #(
    parameter int N_IRQ = 8,
    localparam int LW = $clog2(N_IRQ)
) (
    input  logic [N_IRQ-1:0] req,
    output logic             valid,
    output logic [LW-1:0]    lvl
);
    always_comb begin
        valid = 1'b0;
        lvl   = '0;
        for (int i = 0; i < N_IRQ; i++) begin
            if (req[i]) begin
                valid = 1'b1;
                lvl   = LW'(i);
            end
        end
    end
endmodule

// File: rtl/vic_vec_gen.sv
module vic_vec_gen #(
    parameter int DW = 8,
    parameter int LW = 3
) (
    input  logic [DW-1:0] ctrl,
    input  logic [LW-1:0] lvl,
    output logic [DW-1:0] lo_byte
);
    logic [DW-1:0] base;
    logic [DW-1:0] offs;

    assign base    = {ctrl[DW-1:DW-2], {(DW-2){1'b0}}};
    assign offs    = ctrl[0] ? (DW'(lvl) << 3) : (DW'(lvl) << 2);
    assign lo_byte = base + offs;
endmodule

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl #(
    parameter int N_IRQ = 8,
    parameter int DW    = 8,
    localparam int LW   = $clog2(N_IRQ)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_IRQ-1:0] irq_n,
    input  logic             cascade_n,
    input  logic             cs,
    input  logic [2:0]       sel,
    input  logic             rd,
    input  logic             wr,
    input  logic             fetch,
    input  logic [DW-1:0]    wdata,
    output logic [DW-1:0]    rdata,
    output logic             int_n
);
    import vic_pkg::*;

    fetch_st_t        st_q, st_d;
    logic [DW-1:0]    page_q, ctrl_q;
    logic [N_IRQ-1:0] mask_q;
    logic [N_IRQ-1:0] pend, fall, clr_one;
    logic [LW-1:0]    lvl_live, lvl_q;
    logic             valid_live;
    logic [DW-1:0]    lo_byte;
    logic             fe_en, rd_en, wr_en, status_rd;

    assign fe_en     = cs & fetch;
    assign rd_en     = cs & rd & ~fe_en;
    assign wr_en     = cs & wr;
    assign status_rd = rd_en && (sel == SEL_STAT);
    assign clr_one   = (fe_en && st_q == FS_IDLE && valid_live)
                       ? (N_IRQ'(1) << lvl_live) : '0;

    vic_latch_bank #(.N_IRQ(N_IRQ)) u_latch (
        .clk(clk), .rst_n(rst_n), .req_n(irq_n),
        .clr_all(status_rd), .clr_one(clr_one),
        .pend(pend), .fall(fall)
    );

    vic_prio #(.N_IRQ(N_IRQ)) u_prio (
        .req(pend & ~mask_q), .valid(valid_live), .lvl(lvl_live)
    );

    vic_vec_gen #(.DW(DW), .LW(LW)) u_vec (
        .ctrl(ctrl_q), .lvl(lvl_q), .lo_byte(lo_byte)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= FS_IDLE;
        else        st_q <= st_d;
    end

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            FS_IDLE: if (fe_en) st_d = FS_HI;
            FS_HI:   if (fe_en) st_d = FS_LO;
            FS_LO:   if (fe_en) st_d = FS_IDLE;
            default: st_d = FS_IDLE;
        endcase
    end

    // registers and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            page_q <= '0;
            ctrl_q <= '0;
            mask_q <= '1;
            lvl_q  <= '0;
            rdata  <= '0;
        end else begin
            if (wr_en) begin
                if (sel == SEL_PAGE) page_q <= wdata;
                if (sel == SEL_CTRL) ctrl_q <= wdata;
                if (sel == SEL_MASK) mask_q <= wdata[N_IRQ-1:0];
            end
            if (fe_en) begin
                unique case (st_q)
                    FS_IDLE: begin
                        rdata <= LBR_OPCODE;
                        lvl_q <= valid_live ? lvl_live : '0;
                    end
                    FS_HI:   rdata <= page_q;
                    FS_LO:   rdata <= lo_byte;
                    default: rdata <= '0;
                endcase
            end else if (rd_en) begin
                if (sel == SEL_STAT)      rdata <= DW'(pend);
                else if (sel == SEL_POLL) rdata <= {valid_live, {(DW-1-LW){1'b0}}, lvl_live};
                else                      rdata <= '0;
            end
        end
    end

    assign int_n = ~((|(pend & ~mask_q)) | ~cascade_n);
endmodule

// File: rtl/vic_chk.sv
module vic_chk (
    input logic                clk,
    input logic                rst_n,
    input logic                cs,
    input logic                rd,
    input logic                fetch,
    input logic [2:0]          sel,
    input logic [7:0]          rdata,
    input logic [7:0]          pend,
    input logic [7:0]          fall,
    input logic [7:0]          mask_q,
    input logic [2:0]          lvl_live,
    input logic                valid_live,
    input vic_pkg::fetch_st_t  st_q
);
    import vic_pkg::*;

    // R1
    edge_sets_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fall != 8'h00) |=> ((pend & $past(fall)) == $past(fall)));

    // R4
    status_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs && rd && !fetch && sel == SEL_STAT && fall == 8'h00) |=> (pend == 8'h00));

    // R6
    opcode_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs && fetch && st_q == FS_IDLE) |=> (rdata == 8'hC0 && st_q == FS_HI));

    // R6
    winner_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs && fetch && st_q == FS_IDLE && valid_live && !fall[lvl_live])
        |=> !pend[$past(lvl_live)]);

    // R6
    seq_returns_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs && fetch && st_q == FS_LO) |=> (st_q == FS_IDLE));

    // R10
    reset_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (mask_q == 8'hFF && pend == 8'h00 && st_q == FS_IDLE));
endmodule

bind vec_irq_ctrl vic_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cs(cs), .rd(rd), .fetch(fetch), .sel(sel),
    .rdata(rdata), .pend(pend), .fall(fall), .mask_q(mask_q),
    .lvl_live(lvl_live), .valid_live(valid_live), .st_q(st_q)
);

// File: tb/sim_vec_irq_ctrl.sv
module sim_vec_irq_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] irq_n = 8'hFF;
    logic       cascade_n = 1'b1;
    logic       cs = 1'b0, rd = 1'b0, wr = 1'b0, fetch = 1'b0;
    logic [2:0] sel = 3'd0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       int_n;

    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;

    // model state
    logic [7:0] m_pend = 0, m_mask = 8'hFF, m_page = 0, m_ctrl = 0, m_prev = 8'hFF, m_rdata = 0;
    int         m_st = 0;
    logic [2:0] m_lvl = 0;

    always #2 clk = ~clk;

    vec_irq_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .irq_n(irq_n), .cascade_n(cascade_n),
        .cs(cs), .sel(sel), .rd(rd), .wr(wr), .fetch(fetch),
        .wdata(wdata), .rdata(rdata), .int_n(int_n)
    );

    function automatic logic [3:0] win(input logic [7:0] p, input logic [7:0] m);
        logic [3:0] r = 4'h0;
        for (int i = 0; i < 8; i++) if (p[i] & ~m[i]) r = {1'b1, 3'(i)};
        return r;
    endfunction

    function automatic logic [7:0] lo_of(input logic [7:0] c, input logic [2:0] l);
        return {c[7:6], 6'b0} + (c[0] ? {2'b0, l, 3'b0} : {3'b0, l, 2'b0});
    endfunction

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    // one clock: drive at negedge, model the edge, check after it
    task automatic step(input logic [7:0] i_irq, input logic i_cs, input logic i_rd,
                        input logic i_wr, input logic i_fe, input logic [2:0] i_sel,
                        input logic [7:0] i_wd, input logic i_cas);
        logic [7:0] f, clr;
        logic [3:0] w;
        string tag;
        @(negedge clk);
        irq_n = i_irq; cs = i_cs; rd = i_rd; wr = i_wr; fetch = i_fe;
        sel = i_sel; wdata = i_wd; cascade_n = i_cas;
        f = m_prev & ~i_irq;
        w = win(m_pend, m_mask);
        clr = 8'h00;
        tag = "R5";
        if (i_cs && i_fe) begin
            if (m_st == 0) begin
                m_rdata = 8'hC0; m_lvl = w[3] ? w[2:0] : 3'd0;
                clr = w[3] ? (8'h01 << w[2:0]) : 8'h00; m_st = 1; tag = "R6";
            end else if (m_st == 1) begin
                m_rdata = m_page; m_st = 2; tag = "R6";
            end else begin
                m_rdata = lo_of(m_ctrl, m_lvl); m_st = 0; tag = "R7";
            end
        end else if (i_cs && i_rd) begin
            if (i_sel == 3'd3) begin m_rdata = m_pend; clr = 8'hFF; tag = "R4"; end
            else if (i_sel == 3'd4) begin m_rdata = {w[3], 4'b0, w[2:0]}; tag = "R8"; end
            else m_rdata = 8'h00;
        end
        m_pend = (m_pend & ~clr) | f;
        if (i_cs && i_wr) begin
            if (i_sel == 3'd0) m_page = i_wd;
            if (i_sel == 3'd1) m_ctrl = i_wd;
            if (i_sel == 3'd2) m_mask = i_wd;
        end
        m_prev = i_irq;
        @(posedge clk); #1;
        chk(tag, rdata, m_rdata);
        chk("R3", {7'b0, int_n}, {7'b0, ~((|(m_pend & ~m_mask)) | ~i_cas)});
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) step(irq_n, 0, 0, 0, 0, 0, 0, cascade_n);
    endtask
    task automatic wr_reg(input logic [2:0] s, input logic [7:0] d);
        step(irq_n, 1, 0, 1, 0, s, d, cascade_n);
    endtask
    task automatic rd_reg(input logic [2:0] s);
        step(irq_n, 1, 1, 0, 0, s, 0, cascade_n);
    endtask
    task automatic fe1();
        step(irq_n, 1, 0, 0, 1, 0, 0, cascade_n);
    endtask
    task automatic drop(input int b);
        step(irq_n & ~(8'h01 << b), 0, 0, 0, 0, 0, 0, cascade_n);
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(posedge clk);
        #1;
        chk("R10", rdata, 8'h00);
        chk("R10", {7'b0, int_n}, 8'h01);
        @(negedge clk); rst_n = 1'b1;
        // R10: all lines masked after reset, yet latched
        drop(5);
        chk("R10", {7'b0, int_n}, 8'h01);
        rd_reg(3);                       // R4 status shows masked bit, clears
        chk("R4", rdata, 8'h20);
        rd_reg(3);
        chk("R4", rdata, 8'h00);
        // R1: held low gives no new latch
        idle(3); rd_reg(3);
        chk("R1", rdata, 8'h00);
        step(8'hFF, 0, 0, 0, 0, 0, 0, 1);
        // R2 / R8 priority and polling
        wr_reg(2, 8'h00);
        wr_reg(0, 8'h5A);
        wr_reg(1, 8'h81);                // base 0x80, interval 8
        drop(2); drop(6);
        rd_reg(4);
        chk("R8", rdata, 8'h86);
        chk("R2", {7'b0, int_n}, 8'h00);
        // R6 / R7 / R9: freeze winner 6, raise level 7 mid-sequence
        fe1();
        step(irq_n & 8'h7F, 1, 0, 0, 1, 0, 0, 1);
        chk("R6", rdata, 8'h5A);
        fe1();
        chk("R9", rdata, 8'hB0);
        rd_reg(4);
        chk("R2", rdata, 8'h87);
        rd_reg(3);
        chk("R6", rdata, 8'h84);
        step(8'hFF, 0, 0, 0, 0, 0, 0, 1);
        // R7 interval 4
        wr_reg(1, 8'h40);
        drop(3); fe1(); fe1(); fe1();
        chk("R7", rdata, 8'h4C);
        // R11 cascade only drives int_n
        step(8'hFF, 0, 0, 0, 0, 0, 0, 0);
        chk("R11", {7'b0, int_n}, 8'h00);
        rd_reg(4);
        chk("R11", rdata, 8'h00);
        step(8'hFF, 0, 0, 0, 0, 0, 0, 1);
        chk("R11", {7'b0, int_n}, 8'h01);
        // random traffic
        for (int k = 0; k < 4000; k++) begin
            logic [7:0] ni = irq_n;
            int op = $urandom_range(0, 9);
            if ($urandom_range(0, 3) == 0) ni[$urandom_range(0, 7)] ^= 1'b1;
            step(ni, op != 0, op inside {1, 2, 3}, op inside {4, 5}, op inside {6, 7, 8},
                 3'($urandom_range(0, 6)), 8'($urandom), $urandom_range(0, 7) != 0);
        end
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule